// File: doc/BRIEF.md
# Stuck Rate-Change Receiver Recovery

This block decides, on request, whether a serial link is cleanly up, and repairs one known failure of the physical layer: a receiver that never locks after the link tries to move to its faster rate. It reads two debug status words from the link controller. The first carries a link-up flag and a still-training flag. The second carries the training state machine's current state code. When the link is up and trained, the block answers at once. When the link is up but still training, it waits a fixed interval and samples again, for a bounded number of extra samples.

If the link is down, or training never finishes, the block reads the receiver status register through a PHY register port. It also compares the state code with the receiver-lock code of the Recovery state. A clear receive-valid flag together with that state code marks the transition as stuck. The block then runs a timed receiver reset. It reads the PHY receive-override register, sets the data-enable and PLL-enable override bits, writes the value back, and waits a hold time. Then it reads the register again and writes it back with both bits cleared. All PHY accesses use a request/done port to a separate handshake master.

The result is a held link-up level plus a one-cycle completion pulse. A separate pulse marks a finished recovery.

Top module: `link_rx_recover`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `link_up`, `check_done`, `recov_done` and `phy_req` are 0.
- R2: If a check starts with debug-word bit 4 (link up) = 1 and bit 29 (training) = 0, then `check_done` and `link_up` are 1 one cycle after the edge that accepts `check_req`. No PHY access is made, and `check_done` lasts exactly one cycle.
- R3: While bit 4 = 1 and bit 29 = 1, the words are sampled again every RECHECK_TICKS cycles, at most MAX_RECHECKS extra times. A sample that shows training finished reports `link_up` = 1 without PHY access. If training never finishes, the first PHY request follows the accepting edge by 6 + 5·RECHECK_TICKS cycles under the default count of five.
- R4: When bit 4 = 0, the block goes straight to a PHY read (`phy_we` = 0) of address 0x100D, one cycle after the accepting edge. The same read follows when the extra samples run out. If bit 0 of the returned data (receive valid) is 1, the check ends with `link_up` = 0 and no further access.
- R5: If bits 5:0 of the state word are not 0x0D, the check ends after the 0x100D read with `link_up` = 0 and no further access. Bits above 5 are ignored.
- R6: With receive valid = 0 and state code 0x0D, five accesses follow in this order: read 0x100D, read 0x1005, write 0x1005 with bits 5 and 3 set, read 0x1005, write 0x1005 with bits 5 and 3 cleared. All other bits come from the value just read. Between the end of the first write and the start of the second read there is a gap of HOLD_TICKS cycles with no request.
- R7: `recov_done` pulses for one cycle only at the end of a recovery, in the same cycle as `check_done`, with `link_up` = 0.
- R8: Once raised, `phy_req` stays high with stable `phy_addr`, `phy_we` and `phy_wdata` until a cycle with `phy_done` = 1. That cycle ends the access.
- R9: `check_req` has no effect while a check is in progress, so each accepted check gives exactly one `check_done` pulse.
- R10: `link_up` changes only in a cycle where `check_done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| check_req | input | 1 | Start a link check (accepted when idle) |
| dbg_link | input | DBG_W | Debug word with link-up (bit 4) and training (bit 29) flags |
| dbg_ltssm | input | DBG_W | Debug word whose bits 5:0 give the training state code |
| phy_req | output | 1 | PHY access request, held until done |
| phy_we | output | 1 | 1 = write, 0 = read |
| phy_addr | output | ADDR_W | PHY register address |
| phy_wdata | output | DATA_W | PHY write data |
| phy_done | input | 1 | One-cycle completion of the current PHY access |
| phy_rdata | input | DATA_W | PHY read data, valid with phy_done |
| link_up | output | 1 | Result of the most recent check, held |
| check_done | output | 1 | One-cycle pulse: a check finished |
| recov_done | output | 1 | One-cycle pulse: a receiver recovery finished |

## Verification
The end of a recovery and the report of a check result fall in the same cycle: the acknowledge of the final write-back both pulses `recov_done` and finishes the check. The bench provokes this by first leaving `link_up` at 1 from a trained check. It then presents a down link, a clear receive-valid flag and state code 0x0D, with unrelated high bits set in the state word. At the one sampling point after the last acknowledge, it expects both pulses together and `link_up` back at 0. A second overlap is a new request that arrives while a check is still waiting between training samples. The bench judges that overlap by counting exactly one completion pulse.

// File: rtl/link_rx_recover.sv
module link_rx_recover #(
  parameter int DBG_W          = 32,
  parameter int LINK_BIT       = 4,
  parameter int TRAIN_BIT      = 29,
  parameter int CODE_W         = 6,
  parameter logic [CODE_W-1:0] STUCK_CODE = 6'h0D,
  parameter int ADDR_W         = 16,
  parameter int DATA_W         = 16,
  parameter logic [ADDR_W-1:0] RXSTAT_ADDR = 16'h100D,
  parameter logic [ADDR_W-1:0] OVRD_ADDR   = 16'h1005,
  parameter int RX_VALID_BIT   = 0,
  parameter int RXDATA_EN_BIT  = 5,
  parameter int RXPLL_EN_BIT   = 3,
  parameter int MAX_RECHECKS   = 5,
  parameter int RECHECK_TICKS  = 75000,
  parameter int HOLD_TICKS     = 125000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              check_req,
  input  logic [DBG_W-1:0]  dbg_link,
  input  logic [DBG_W-1:0]  dbg_ltssm,
  output logic              phy_req,
  output logic              phy_we,
  output logic [ADDR_W-1:0] phy_addr,
  output logic [DATA_W-1:0] phy_wdata,
  input  logic              phy_done,
  input  logic [DATA_W-1:0] phy_rdata,
  output logic              link_up,
  output logic              check_done,
  output logic              recov_done
);

  localparam int TMAX = (RECHECK_TICKS > HOLD_TICKS) ? RECHECK_TICKS : HOLD_TICKS;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int CW   = $clog2(MAX_RECHECKS + 2);
  localparam logic [TW-1:0] RECHECK_LOAD = TW'(RECHECK_TICKS - 1);
  localparam logic [TW-1:0] HOLD_LOAD    = TW'(HOLD_TICKS - 1);
  localparam logic [CW-1:0] TRIES_LAST   = CW'(MAX_RECHECKS);
  localparam logic [DATA_W-1:0] OVRD_MASK =
    (DATA_W'(1) << RXDATA_EN_BIT) | (DATA_W'(1) << RXPLL_EN_BIT);

  typedef enum logic [3:0] {
    S_IDLE, S_SAMPLE, S_PAUSE, S_RXSTAT,
    S_RD_SET, S_WR_SET, S_HOLD, S_RD_CLR, S_WR_CLR
  } st_t;

  st_t               state;
  logic [TW-1:0]     tmr;
  logic [CW-1:0]     tries;
  logic [DATA_W-1:0] ovrd_q;

  wire is_up    = dbg_link[LINK_BIT];
  wire training = dbg_link[TRAIN_BIT];
  wire [CODE_W-1:0] code = dbg_ltssm[CODE_W-1:0];
  wire unused_dbg = ^{dbg_link, dbg_ltssm};
  wire looks_stuck = !phy_rdata[RX_VALID_BIT] && (code == STUCK_CODE);

  assign phy_req = (state == S_RXSTAT) || (state == S_RD_SET) || (state == S_WR_SET) ||
                   (state == S_RD_CLR) || (state == S_WR_CLR);
  assign phy_we    = (state == S_WR_SET) || (state == S_WR_CLR);
  assign phy_addr  = (state == S_RXSTAT) ? RXSTAT_ADDR : OVRD_ADDR;
  assign phy_wdata = phy_we ? ovrd_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      tmr        <= '0;
      tries      <= '0;
      ovrd_q     <= '0;
      link_up    <= 1'b0;
      check_done <= 1'b0;
      recov_done <= 1'b0;
    end else begin
      check_done <= 1'b0;
      recov_done <= 1'b0;
      case (state)
        S_IDLE: if (check_req) begin
          state <= S_SAMPLE;
          tries <= '0;
        end
        S_SAMPLE: begin
          if (!is_up) state <= S_RXSTAT;
          else if (!training) begin
            link_up    <= 1'b1;
            check_done <= 1'b1;
            state      <= S_IDLE;
          end else if (tries == TRIES_LAST) state <= S_RXSTAT;
          else begin
            tries <= tries + 1'b1;
            tmr   <= RECHECK_LOAD;
            state <= S_PAUSE;
          end
        end
        S_PAUSE: begin
          if (tmr == '0) state <= S_SAMPLE;
          else tmr <= tmr - 1'b1;
        end
        S_RXSTAT: if (phy_done) begin
          if (looks_stuck) state <= S_RD_SET;
          else begin
            link_up    <= 1'b0;
            check_done <= 1'b1;
            state      <= S_IDLE;
          end
        end
        S_RD_SET: if (phy_done) begin
          ovrd_q <= phy_rdata | OVRD_MASK;
          state  <= S_WR_SET;
        end
        S_WR_SET: if (phy_done) begin
          tmr   <= HOLD_LOAD;
          state <= S_HOLD;
        end
        S_HOLD: begin
          if (tmr == '0) state <= S_RD_CLR;
          else tmr <= tmr - 1'b1;
        end
        S_RD_CLR: if (phy_done) begin
          ovrd_q <= phy_rdata & ~OVRD_MASK;
          state  <= S_WR_CLR;
        end
        S_WR_CLR: if (phy_done) begin
          link_up    <= 1'b0;
          check_done <= 1'b1;
          recov_done <= 1'b1;
          state      <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R8: an access holds its request and fields until acknowledged
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_req && !phy_done) |=> (phy_req && $stable(phy_addr) && $stable(phy_we) && $stable(phy_wdata)));

  // R7: recovery completion coincides with a not-up report
  p_recov_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    recov_done |-> (check_done && !link_up));

  // R2: completion is a single-cycle pulse
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    check_done |=> !check_done);

  // R10: the result level moves only with a completion
  p_link_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(link_up) |-> check_done);

endmodule

// File: tb/link_rx_recover_bench.sv
module link_rx_recover_bench;
  localparam int RT  = 4;
  localparam int HT  = 10;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        check_req = 1'b0;
  logic [31:0] dbg_link = '0;
  logic [31:0] dbg_ltssm = '0;
  logic        phy_req, phy_we;
  logic [15:0] phy_addr, phy_wdata;
  logic        phy_done = 1'b0;
  logic [15:0] phy_rdata = '0;
  logic        link_up, check_done, recov_done;

  int total = 0;
  int bad = 0;

  link_rx_recover #(.RECHECK_TICKS(RT), .HOLD_TICKS(HT)) u_link_rx_recover (
    .clk(clk), .rst_n(rst_n), .check_req(check_req),
    .dbg_link(dbg_link), .dbg_ltssm(dbg_ltssm),
    .phy_req(phy_req), .phy_we(phy_we), .phy_addr(phy_addr), .phy_wdata(phy_wdata),
    .phy_done(phy_done), .phy_rdata(phy_rdata),
    .link_up(link_up), .check_done(check_done), .recov_done(recov_done));

  always #10 clk = ~clk;

  // PHY register model
  logic [15:0] ovrd_reg = 16'h1234;
  logic [15:0] rxstat_reg = 16'h0000;
  int n_tx = 0;
  int cyc = 0;
  int lat_cnt = 0;
  logic [15:0] tx_addr [16];
  logic        tx_we   [16];
  logic [15:0] tx_data [16];
  int          tx_start[16];
  int          tx_end  [16];

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (phy_done) phy_done = 1'b0;
      else if (phy_req) begin
        if (lat_cnt == 0 && n_tx < 16) tx_start[n_tx] = cyc;
        if (lat_cnt == LAT) begin
          if (n_tx < 16) begin
            tx_addr[n_tx] = phy_addr;
            tx_we[n_tx]   = phy_we;
            tx_data[n_tx] = phy_wdata;
            tx_end[n_tx]  = cyc;
          end
          if (phy_we && phy_addr == 16'h1005) ovrd_reg = phy_wdata;
          phy_rdata = (phy_addr == 16'h100D) ? rxstat_reg :
                      (phy_addr == 16'h1005) ? ovrd_reg : 16'h0000;
          phy_done = 1'b1;
          n_tx++;
          lat_cnt = 0;
        end else lat_cnt++;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse_req();
    @(negedge clk) check_req = 1'b1;
    @(negedge clk) check_req = 1'b0;
  endtask

  // waits at negedges for check_done; returns recov_done seen with it
  task automatic wait_done(output logic got, output logic rec);
    got = 1'b0; rec = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if (check_done) begin got = 1'b1; rec = recov_done; break; end
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 link_up in reset", link_up, 0);
    chk("R1 check_done in reset", check_done, 0);
    chk("R1 phy_req in reset", phy_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 recov_done after reset", recov_done, 0);
    chk("R1 link_up after reset", link_up, 0);
  endtask

  task automatic t_trained();
    n_tx = 0;
    dbg_link = 32'h0000_0010;
    pulse_req();
    @(negedge clk);
    chk("R2 check_done timing", check_done, 1);
    chk("R2 link_up", link_up, 1);
    @(negedge clk);
    chk("R2 done is one cycle", check_done, 0);
    chk("R2 no phy access", n_tx, 0);
  endtask

  task automatic t_training_ends();
    int pulses = 0;
    n_tx = 0;
    dbg_link = 32'h2000_0010;
    pulse_req();
    repeat (3) @(negedge clk);
    check_req = 1'b1;
    @(negedge clk) check_req = 1'b0;
    repeat (5) @(negedge clk);
    dbg_link = 32'h0000_0010;
    for (int i = 0; i < 60; i++) begin
      if (check_done) pulses++;
      @(negedge clk);
    end
    chk("R3 up after training ends", link_up, 1);
    chk("R3 no phy access", n_tx, 0);
    chk("R9 single done for overlapping request", pulses, 1);
  endtask

  task automatic t_training_timeout();
    int n = 1;
    logic got, rec;
    n_tx = 0;
    dbg_link = 32'h2000_0010;
    dbg_ltssm = 32'h0000_000D;
    rxstat_reg = 16'h0001;
    pulse_req();
    while (!phy_req && n < 500) begin @(negedge clk); n++; end
    chk("R3 cycles to first phy request", n, 7 + 5 * RT);
    wait_done(got, rec);
    chk("R4 done after valid receiver", got, 1);
    chk("R4 link_up low", link_up, 0);
    chk("R4 single access", n_tx, 1);
    chk("R4 address 0x100D", tx_addr[0], 16'h100D);
    chk("R4 access is read", tx_we[0], 0);
    chk("R7 no recovery pulse", rec, 0);
  endtask

  task automatic t_wrong_code();
    int n = 1;
    logic got, rec;
    t_trained();
    n_tx = 0;
    dbg_link = 32'h0000_0000;
    dbg_ltssm = 32'h0000_000C;
    rxstat_reg = 16'hFFFE;
    pulse_req();
    while (!phy_req && n < 500) begin @(negedge clk); n++; end
    chk("R4 down link reads at once", n, 2);
    wait_done(got, rec);
    chk("R5 done", got, 1);
    chk("R5 link_up low", link_up, 0);
    chk("R5 only status read", n_tx, 1);
    chk("R5 no recovery", rec, 0);
  endtask

  task automatic t_stuck();
    logic got, rec;
    t_trained();
    n_tx = 0;
    ovrd_reg = 16'h1234;
    dbg_link = 32'h0000_0000;
    dbg_ltssm = 32'hABCD_12CD;
    rxstat_reg = 16'hFFFE;
    pulse_req();
    wait_done(got, rec);
    chk("R7 check_done at end", got, 1);
    chk("R7 recov_done with check_done", rec, 1);
    chk("R7 link_up low", link_up, 0);
    chk("R6 access count", n_tx, 5);
    chk("R6 tx0 addr", tx_addr[0], 16'h100D);
    chk("R6 tx1 read 0x1005", {tx_we[1], tx_addr[1]}, {1'b0, 16'h1005});
    chk("R6 tx2 write 0x1005", {tx_we[2], tx_addr[2]}, {1'b1, 16'h1005});
    chk("R6 set value", tx_data[2], 16'h123C);
    chk("R6 tx3 read 0x1005", {tx_we[3], tx_addr[3]}, {1'b0, 16'h1005});
    chk("R6 tx4 write 0x1005", {tx_we[4], tx_addr[4]}, {1'b1, 16'h1005});
    chk("R6 cleared value", tx_data[4], 16'h1214);
    chk("R6 hold gap", tx_start[3] - tx_end[2], HT + 1);
    @(negedge clk);
    chk("R7 recov_done one cycle", recov_done, 0);
    chk("R10 link_up held", link_up, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_trained();
    t_training_ends();
    t_training_timeout();
    t_wrong_code();
    t_stuck();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule